// File: doc/BRIEF.md
# Byte Prefetch Queue with Derived Instruction Pointer

This block sits between the bus interface and the instruction decoder of a small two-stage fetch/execute processor. It requests 16-bit words from memory, stores their bytes in a short queue, and passes those bytes to the decoder in order. The decoder may take zero, one or two bytes in any cycle. The only offset register the block holds is a fetch pointer. That pointer names the next 16-bit word to be brought into the queue. It does not name any instruction.

The architectural instruction pointer is never stored. It is derived every cycle as the fetch pointer minus the number of bytes still queued. The result is the offset just past the last byte the decoder consumed, which is the start of the next instruction. It is exported so that a call can push it as its return address. On a taken relative control transfer, the target is this derived offset plus a signed displacement. The queue is emptied in the same cycle, fetch restarts at the target, and any word already requested is thrown away when it arrives. Physical word addresses are formed by shifting the 16-bit code segment left by four bits and adding the word-aligned offset.

Top module: `ipq_prefetch`

## Requirements
- R1: After reset the queue is empty (`dec_avail` = 0), `arch_ip` equals the reset offset (0 by default), and a word request is offered at the code segment base.
- R2: `req_valid` is high exactly when no request is outstanding, at least 2 bytes of the queue are free and `br_take` is low. At most one request is outstanding at a time. `req_addr` = (`code_seg` << 4) + (fetch pointer with bit 0 cleared), 20 bits wide.
- R3: A word returning from the bus never changes `arch_ip`. The fetch pointer and the occupancy both grow by the number of bytes the word adds.
- R4: `dec_avail` = min(occupancy, 2). `dec_byte0` is the oldest queued byte and `dec_byte1` the next one. Taking N bytes (0 to 2, N <= `dec_avail`) removes them and raises `arch_ip` by N.
- R5: When a returning word and decoder consumption fall in the same cycle, the occupancy becomes old − taken + added, and byte order is preserved. For a word fetched at an even offset, the low data byte (bits 7:0) enters the queue before the high byte (bits 15:8).
- R6: When `br_take` is high, the next `arch_ip` is the current `arch_ip` + `br_disp` (two's complement, modulo 2^16). The queue is empty in the next cycle, `dec_take` is ignored in that cycle, and fetching restarts at the target.
- R7: A response to a request accepted before a taken transfer, or one arriving in the transfer cycle, is discarded. No byte of it reaches the decoder.
- R8: For an odd target, the first request goes to the even word address below the target. Only that word's high byte (bits 15:8) enters the queue, and the fetch pointer then advances by 1.
- R9: Offset arithmetic wraps modulo 2^16 and never carries into the segment. After the word at offset 0xFFFE, the next request is at the segment base.
- R10: With no consumption, the queue fills to its depth (6 bytes by default, 4 as a parameter option) and then stops requesting. From empty, exactly depth/2 words are accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| code_seg | input | 16 | Code segment value |
| req_valid | output | 1 | Word request offered |
| req_ready | input | 1 | Bus accepts the request this cycle |
| req_addr | output | 20 | Physical address of the requested word (even) |
| rsp_valid | input | 1 | Requested word is returning |
| rsp_data | input | 16 | Returning word, low byte at the even address |
| dec_avail | output | 2 | Number of bytes presented to the decoder (0 to 2) |
| dec_byte0 | output | 8 | Oldest queued byte |
| dec_byte1 | output | 8 | Second oldest queued byte |
| dec_take | input | 2 | Bytes the decoder consumes this cycle |
| br_take | input | 1 | Taken relative control transfer |
| br_disp | input | 16 | Signed displacement of the transfer |
| arch_ip | output | 16 | Derived architectural next-instruction offset |

## Verification
The assertions take four things for granted about the inputs. The decoder never takes more bytes than `dec_avail` shows, except in a transfer cycle, where its count is ignored. `rsp_valid` comes only while a request is outstanding. Each accepted request gets exactly one response. The bench's bus model follows these rules: it answers each accepted request once after a chosen latency of one to four cycles. The decoder model clips its wanted byte count to `dec_avail` in normal cycles and deliberately offers the full `dec_avail` in transfer cycles, so the ignore rule is exercised.

// File: rtl/ipq_pkg.sv
package ipq_pkg;

   // How many bytes a returning word contributes to the queue
   typedef enum logic [1:0] {
      FILL_NONE = 2'd0,
      FILL_HI   = 2'd1,
      FILL_BOTH = 2'd2
   } fill_e;

   function automatic logic [1:0] fill_len(input fill_e f);
      case (f)
         FILL_HI:   fill_len = 2'd1;
         FILL_BOTH: fill_len = 2'd2;
         default:   fill_len = 2'd0;
      endcase
   endfunction

endpackage

// File: rtl/ipq_byte_queue.sv
module ipq_byte_queue
   import ipq_pkg::*;
#(
   parameter int QDEPTH = 6,
   localparam int CNT_W = $clog2(QDEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic [1:0]       take,
   input  fill_e            fill,
   input  logic [15:0]      fill_word,
   output logic [CNT_W-1:0] count,
   output logic [7:0]       head0,
   output logic [7:0]       head1
);

   logic [7:0]       slots [QDEPTH];
   logic [7:0]       nxt   [QDEPTH];
   logic [CNT_W-1:0] keep;
   logic [CNT_W-1:0] count_n;
   logic [7:0]       fb0, fb1;

   always_comb begin
      fb0 = fill_word[7:0];
      fb1 = fill_word[15:8];
      if (fill == FILL_HI) fb0 = fill_word[15:8];
   end

   assign keep    = flush ? '0 : count - CNT_W'(take);
   assign count_n = keep + CNT_W'(fill_len(fill));

   always_comb begin
      for (int i = 0; i < QDEPTH; i++) begin
         int src;
         src    = i + int'(take);
         nxt[i] = slots[i];
         if (i < int'(keep) && src < QDEPTH)  nxt[i] = slots[src[CNT_W-1:0]];
         else if (i == int'(keep))            nxt[i] = fb0;
         else if (i == int'(keep) + 1)        nxt[i] = fb1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
         for (int j = 0; j < QDEPTH; j++) slots[j] <= '0;
      end else begin
         count <= count_n;
         for (int j = 0; j < QDEPTH; j++) slots[j] <= nxt[j];
      end
   end

   assign head0 = slots[0];
   assign head1 = slots[1];

   // R10
   occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CNT_W'(QDEPTH));

   // R4
   take_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !flush |-> CNT_W'(take) <= count);

   // R2
   fill_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fill != FILL_NONE) |-> count <= CNT_W'(QDEPTH - 2));

endmodule

// File: rtl/ipq_fetch_ptr.sv
module ipq_fetch_ptr #(
   parameter int           OFS_W    = 16,
   parameter logic [OFS_W-1:0] RESET_IP = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             redirect,
   input  logic [OFS_W-1:0] target,
   input  logic [1:0]       advance,
   output logic [OFS_W-1:0] ptr
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        ptr <= RESET_IP;
      else if (redirect) ptr <= target;
      else               ptr <= ptr + OFS_W'(advance);
   end

   // R9
   ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !redirect |=> ptr - $past(ptr) <= OFS_W'(2));

endmodule

// File: rtl/ipq_bus_track.sv
module ipq_bus_track (
   input  logic clk,
   input  logic rst_n,
   input  logic req_fire,
   input  logic rsp_valid,
   input  logic redirect,
   output logic pending,
   output logic rsp_keep
);

   logic drop;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pending <= 1'b0;
         drop    <= 1'b0;
      end else begin
         if (req_fire)       pending <= 1'b1;
         else if (rsp_valid) pending <= 1'b0;
         if (rsp_valid)      drop <= 1'b0;
         else if (redirect && pending) drop <= 1'b1;
      end
   end

   assign rsp_keep = rsp_valid && !drop && !redirect;

   // R2
   one_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pending |-> !req_fire);

   // R7
   rsp_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> pending);

   // R7
   stale_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (redirect && pending && !rsp_valid) |=> (rsp_valid |-> !rsp_keep));

endmodule

// File: rtl/ipq_prefetch.sv
module ipq_prefetch
   import ipq_pkg::*;
#(
   parameter int QDEPTH    = 6,
   parameter int OFS_W     = 16,
   parameter int SEG_W     = 16,
   parameter int SEG_SHIFT = 4,
   parameter logic [OFS_W-1:0] RESET_IP = '0,
   localparam int ADDR_W = SEG_W + SEG_SHIFT,
   localparam int CNT_W  = $clog2(QDEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [SEG_W-1:0]  code_seg,
   output logic              req_valid,
   input  logic              req_ready,
   output logic [ADDR_W-1:0] req_addr,
   input  logic              rsp_valid,
   input  logic [15:0]       rsp_data,
   output logic [1:0]        dec_avail,
   output logic [7:0]        dec_byte0,
   output logic [7:0]        dec_byte1,
   input  logic [1:0]        dec_take,
   input  logic              br_take,
   input  logic [OFS_W-1:0]  br_disp,
   output logic [OFS_W-1:0]  arch_ip
);

   if (QDEPTH < 4 || QDEPTH > 14 || (QDEPTH % 2) != 0) begin : g_bad_depth
      $error("ipq_prefetch: QDEPTH must be even and between 4 and 14");
   end
   if (OFS_W > ADDR_W || OFS_W < 2) begin : g_bad_ofs
      $error("ipq_prefetch: OFS_W must fit the physical address");
   end

   logic [CNT_W-1:0] count;
   logic [OFS_W-1:0] ptr;
   logic [OFS_W-1:0] target;
   logic [OFS_W-1:0] word_ofs;
   logic             pending, rsp_keep, req_fire;
   fill_e            fill;

   assign arch_ip   = ptr - OFS_W'(count);
   assign target    = arch_ip + br_disp;
   assign req_valid = !pending && (count <= CNT_W'(QDEPTH - 2)) && !br_take;
   assign req_fire  = req_valid && req_ready;
   assign word_ofs  = {ptr[OFS_W-1:1], 1'b0};
   assign fill      = !rsp_keep ? FILL_NONE : (ptr[0] ? FILL_HI : FILL_BOTH);
   assign dec_avail = (count >= CNT_W'(2)) ? 2'd2 : count[1:0];

   if (SEG_SHIFT == 0) begin : g_flat
      assign req_addr = ADDR_W'(code_seg) + ADDR_W'(word_ofs);
   end else begin : g_shift
      assign req_addr = {code_seg, {SEG_SHIFT{1'b0}}} + ADDR_W'(word_ofs);
   end

   ipq_byte_queue #(.QDEPTH(QDEPTH)) i_queue (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (br_take),
      .take      (br_take ? 2'd0 : dec_take),
      .fill      (fill),
      .fill_word (rsp_data),
      .count     (count),
      .head0     (dec_byte0),
      .head1     (dec_byte1)
   );

   ipq_fetch_ptr #(.OFS_W(OFS_W), .RESET_IP(RESET_IP)) i_ptr (
      .clk      (clk),
      .rst_n    (rst_n),
      .redirect (br_take),
      .target   (target),
      .advance  (fill_len(fill)),
      .ptr      (ptr)
   );

   ipq_bus_track i_bus (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_fire  (req_fire),
      .rsp_valid (rsp_valid),
      .redirect  (br_take),
      .pending   (pending),
      .rsp_keep  (rsp_keep)
   );

   // R6
   redirect_ip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      br_take |=> arch_ip == $past(arch_ip + br_disp));

   // R6
   redirect_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
      br_take |=> dec_avail == 2'd0);

   // R3
   ip_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !br_take |=> arch_ip == $past(arch_ip) + OFS_W'($past(dec_take)));

   // R2
   req_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_fire |=> !req_valid);

   // R8
   odd_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_keep && ptr[0] && dec_take == 2'd0) |=> dec_avail == $past(dec_avail) + 2'd1 || $past(dec_avail) == 2'd2);

endmodule

// File: tb/test_ipq_prefetch.sv
module test_ipq_prefetch;
   timeunit 1ns;
   timeprecision 1ps;

   localparam int QDEPTH = 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] code_seg = 16'h1234;
   logic        req_valid;
   logic        req_ready = 1'b0;
   logic [19:0] req_addr;
   logic        rsp_valid = 1'b0;
   logic [15:0] rsp_data = '0;
   logic [1:0]  dec_avail;
   logic [7:0]  dec_byte0, dec_byte1;
   logic [1:0]  dec_take = '0;
   logic        br_take = 1'b0;
   logic [15:0] br_disp = '0;
   logic [15:0] arch_ip;

   always #5 clk = ~clk;

   ipq_prefetch #(.QDEPTH(QDEPTH)) i_ipq_prefetch (
      .clk(clk), .rst_n(rst_n), .code_seg(code_seg),
      .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
      .rsp_valid(rsp_valid), .rsp_data(rsp_data),
      .dec_avail(dec_avail), .dec_byte0(dec_byte0), .dec_byte1(dec_byte1),
      .dec_take(dec_take), .br_take(br_take), .br_disp(br_disp),
      .arch_ip(arch_ip)
   );

   int n_chk = 0;
   int n_bad = 0;
   string tag = "R1";

   // bench model state
   logic [15:0] exp_ip  = 16'h0000;
   logic [15:0] exp_ptr = 16'h0000;
   logic [19:0] pend_addr = '0;
   bit          pend_b = 0, drop_b = 0, rdy_en = 1;
   int          cd = 0, lat = 2, n_req = 0;
   logic [7:0]  sb [$];

   function automatic logic [7:0] mb(input logic [19:0] a);
      return a[7:0] ^ (a[15:8] * 8'd3) ^ ({4'h0, a[19:16]} * 8'd7);
   endfunction

   task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic step(input int want, input bit br, input logic [15:0] disp);
      int exp_cnt, take, exp_av;
      bit rv, rq, was_pend;
      @(negedge clk);
      exp_cnt = int'(16'(exp_ptr - exp_ip));
      exp_av  = (exp_cnt > 2) ? 2 : exp_cnt;
      chk(int'(dec_avail) == exp_av, "byte count", 32'(dec_avail), 32'(exp_av));
      chk(arch_ip == exp_ip, "arch_ip", 32'(arch_ip), 32'(exp_ip));
      if (br) take = int'(dec_avail);
      else    take = (want < int'(dec_avail)) ? want : int'(dec_avail);
      if (!br) begin
         for (int k = 0; k < take; k++) begin
            logic [7:0] e, g;
            e = (sb.size() > 0) ? sb.pop_front() : 8'hxx;
            g = (k == 0) ? dec_byte0 : dec_byte1;
            chk(g === e, "decoder byte", 32'(g), 32'(e));
         end
      end
      rv = pend_b && (cd == 0);
      rsp_valid = rv;
      rsp_data  = rv ? {mb(pend_addr + 20'd1), mb(pend_addr)} : 16'h0000;
      dec_take  = 2'(take);
      br_take   = br;
      br_disp   = disp;
      req_ready = rdy_en;
      #1;
      rq = !pend_b && !br && (QDEPTH - exp_cnt >= 2);
      chk(req_valid == rq, "req_valid", 32'(req_valid), 32'(rq));
      if (req_valid && rq)
         chk(req_addr == ({code_seg, 4'h0} + {4'h0, exp_ptr[15:1], 1'b0}), "req_addr",
             32'(req_addr), 32'({code_seg, 4'h0} + {4'h0, exp_ptr[15:1], 1'b0}));
      // model update for the coming edge
      was_pend = pend_b;
      if (rv) begin
         pend_b = 0;
         if (!drop_b && !br) begin
            if (exp_ptr[0]) begin
               sb.push_back(mb(pend_addr + 20'd1));
               exp_ptr = exp_ptr + 16'd1;
            end else begin
               sb.push_back(mb(pend_addr));
               sb.push_back(mb(pend_addr + 20'd1));
               exp_ptr = exp_ptr + 16'd2;
            end
         end
         drop_b = 0;
      end else if (pend_b) begin
         cd--;
         if (br) drop_b = 1;
      end
      if (!was_pend && req_valid && rdy_en) begin
         pend_b    = 1;
         cd        = lat - 1;
         pend_addr = req_addr;
         n_req++;
      end
      if (br) begin
         exp_ip  = exp_ip + disp;
         exp_ptr = exp_ip;
         sb.delete();
      end else begin
         exp_ip = exp_ip + 16'(take);
      end
   endtask

   initial begin
      #(200000 * 10);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1 reset state
      tag = "R1";
      chk(arch_ip == 16'h0000, "reset arch_ip", 32'(arch_ip), 32'h0);
      chk(dec_avail == 2'd0, "reset dec_avail", 32'(dec_avail), 32'h0);
      chk(req_valid == 1'b1, "reset req_valid", 32'(req_valid), 32'h1);
      chk(req_addr == 20'h12340, "reset req_addr", 32'(req_addr), 32'h12340);

      // R10 / R3: fill without consumption
      tag = "R10"; lat = 2; n_req = 0;
      for (int i = 0; i < 20; i++) step(0, 0, 16'h0);
      chk(n_req == QDEPTH / 2, "words accepted into empty queue", 32'(n_req), 32'(QDEPTH / 2));
      tag = "R3";
      chk(arch_ip == 16'h0000, "arch_ip after fills", 32'(arch_ip), 32'h0);

      // R4: single and double byte consumption
      tag = "R4"; lat = 1;
      for (int i = 0; i < 3; i++) step(1, 0, 16'h0);
      for (int i = 0; i < 6; i++) step(2, 0, 16'h0);

      // R5: mixed fill and consume
      tag = "R5";
      for (int i = 0; i < 80; i++) begin
         lat    = (i % 3) + 1;
         rdy_en = (i % 5) != 0;
         step((i * 7) % 3, 0, 16'h0);
      end
      rdy_en = 1;

      // R6: forward and backward transfers, take ignored
      tag = "R6"; lat = 2;
      for (int i = 0; i < 4; i++) step(0, 0, 16'h0);
      step(0, 1, 16'd15);
      for (int i = 0; i < 12; i++) step(2, 0, 16'h0);
      step(0, 1, 16'hFFD8);
      for (int i = 0; i < 12; i++) step(1, 0, 16'h0);

      // R7: transfer while a word is in flight
      tag = "R7"; lat = 4;
      for (int i = 0; i < 20; i++) begin
         if (pend_b && cd > 0) break;
         step(2, 0, 16'h0);
      end
      chk(pend_b, "request outstanding before transfer", 32'(pend_b), 32'h1);
      step(0, 1, 16'd100);
      lat = 1;
      for (int i = 0; i < 20; i++) step(1, 0, 16'h0);

      // R8: odd target
      tag = "R8"; lat = 2;
      step(0, 1, 16'h4567 - exp_ip);
      for (int i = 0; i < 16; i++) step(1, 0, 16'h0);

      // R9: wrap inside the segment
      tag = "R9"; code_seg = 16'h2000;
      step(0, 1, 16'hFFFF - exp_ip);
      for (int i = 0; i < 16; i++) step(1, 0, 16'h0);
      chk(exp_ip[15:4] == 12'h000, "model wrapped", 32'(exp_ip), 32'h0);

      @(negedge clk);
      dec_take = '0; br_take = 1'b0; rsp_valid = 1'b0; req_ready = 1'b0;
      repeat (2) @(negedge clk);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule